// File: doc/BRIEF.md
# RGB565 Camera Pixel Capture with Frame Decimation

This block sits on the pixel-clock side of a camera input path. The sensor presents one byte per pixel clock on an 8-bit bus, with a line-valid strobe and a frame-sync strobe. The block pairs consecutive bytes into 16-bit RGB565 pixels and trims each one to a 12-bit word with 4 bits per colour. It then emits one write per pixel toward a frame memory: a running 19-bit pixel index, the 12-bit colour word and a single-cycle write strobe.

The frame memory holds 131072 words. A full 640x480 frame has more pixels than that, so in full-resolution mode the memory address drops the two low bits of the pixel index. Four neighbouring pixels then share one word and the last one written wins. In the 320x240 and 160x120 modes the frame fits as it is, and the low 17 bits of the index address the memory directly. Two select pins choose the mode. The pixel index restarts at zero during frame sync and is never reset by a line boundary.

Top module: `pixcap_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its outputs: `wr_en` is 0, `wr_addr` is 0 and `wr_data` is 0 after that edge.
- R2: The first byte of a pair carries red[4:0] in bits 7:3 and green[5:3] in bits 2:0. The second byte carries green[2:0] in bits 7:5 and blue[4:0] in bits 4:0. `wr_data` is {red[4:1], green[5:2], blue[4:1]}, with red in bits 11:8 and blue in bits 3:0.
- R3: `wr_en` is high for exactly one clock, in the cycle after the edge that samples the second byte of a pair. It is low after the edge that samples a first byte.
- R4: When `line_valid` is low at a rising edge, the byte phase returns to "first byte". An unpaired byte left over before the line ended never becomes part of a pixel.
- R5: `wr_addr` is the index of the pixel being written. It is one greater than the index of the previous write in the same frame.
- R6: When `frame_sync` is high at a rising edge, the next pixel index returns to 0. Bytes sampled while `frame_sync` is high produce no write, even if `line_valid` is high. The first pixel after sync is written at index 0.
- R7: With `sel_half` and `sel_quarter` both low (full 640x480 mode), `mem_addr` equals `wr_addr[18:2]`.
- R8: With `sel_half` or `sel_quarter` high (320x240 or 160x120 mode; both high acts the same), `mem_addr` equals `wr_addr[16:0]`. The change is combinational and takes effect without a clock edge.
- R9: In a cycle after an edge where `line_valid` was low, `wr_en` is 0, and `wr_addr` and `wr_data` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the sensor |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame sync, active high; restarts the pixel index |
| line_valid | input | 1 | High while the bus carries line bytes |
| pix_byte | input | 8 | Sensor data byte |
| sel_half | input | 1 | Select 320x240 addressing |
| sel_quarter | input | 1 | Select 160x120 addressing |
| wr_en | output | 1 | One-cycle write strobe per pixel |
| wr_addr | output | 19 | Pixel index of the current write |
| wr_data | output | 12 | 4:4:4 colour word |
| mem_addr | output | 17 | Frame memory word address for the current write |

## Verification
`wr_en`, `wr_data` and `wr_addr` are registered. They are due one pixel clock after the edge that samples the second byte of a pair, and they stay unchanged through the next first-byte edge. `mem_addr` is combinational from the registered index and the select pins, so it follows a select change at once. The bench changes inputs on the falling edge and samples 1 ns after each rising edge, so every check reads the result of exactly one edge. Select-pin checks are made right after the pins move, before the next rising edge.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

    localparam int BYTE_W      = 8;
    localparam int PIX_W       = 12;
    localparam int FRAME_AW    = 19;
    localparam int MEM_AW      = 17;

    typedef enum logic {
        MODE_FULL    = 1'b0,
        MODE_REDUCED = 1'b1
    } addr_mode_e;

    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } rgb565_t;

    typedef struct packed {
        logic [3:0] r;
        logic [3:0] g;
        logic [3:0] b;
    } rgb444_t;

    // first byte occupies the upper half of the 16-bit pixel
    function automatic rgb565_t join_bytes(input logic [7:0] first_b,
                                           input logic [7:0] second_b);
        return rgb565_t'({first_b, second_b});
    endfunction

    // keep the most significant four bits of every channel
    function automatic rgb444_t shrink(input rgb565_t p);
        rgb444_t q;
        q.r = p.r[4:1];
        q.g = p.g[5:2];
        q.b = p.b[4:1];
        return q;
    endfunction

    function automatic addr_mode_e pick_mode(input logic half, input logic quarter);
        return (half || quarter) ? MODE_REDUCED : MODE_FULL;
    endfunction

endpackage

// File: rtl/pixcap_pairer.sv
module pixcap_pairer
    import pixcap_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_sync,
    input  logic          line_valid,
    input  logic [DW-1:0] pix_byte,
    output logic          pix_stb,
    output rgb565_t       pix
);
    logic          second_q;
    logic [DW-1:0] first_byte_q;
    logic          take;

    assign take = line_valid && !frame_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q     <= 1'b0;
            first_byte_q <= '0;
        end else if (!take) begin
            second_q <= 1'b0;
        end else begin
            second_q <= !second_q;
            if (!second_q) first_byte_q <= pix_byte;
        end
    end

    assign pix_stb = take && second_q;
    assign pix     = join_bytes(first_byte_q, pix_byte);

endmodule

// File: rtl/pixcap_addr_ctr.sv
module pixcap_addr_ctr
    import pixcap_pkg::*;
#(
    parameter int AW = FRAME_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_sync,
    input  logic          pix_stb,
    output logic [AW-1:0] wr_addr
);
    logic [AW-1:0] next_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_idx_q <= '0;
            wr_addr    <= '0;
        end else if (frame_sync) begin
            next_idx_q <= '0;
        end else if (pix_stb) begin
            wr_addr    <= next_idx_q;
            next_idx_q <= next_idx_q + 1'b1;
        end
    end

    // R6: sync leaves the counter pointing at index zero
    p_sync_clears_r6: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (next_idx_q == '0));

endmodule

// File: rtl/pixcap_addr_map.sv
module pixcap_addr_map
    import pixcap_pkg::*;
#(
    parameter int AW  = FRAME_AW,
    parameter int MAW = MEM_AW
) (
    input  logic [AW-1:0]  frame_addr,
    input  logic           sel_half,
    input  logic           sel_quarter,
    output logic [MAW-1:0] mem_addr
);
    localparam int DROP = AW - MAW;

    addr_mode_e mode;
    assign mode = pick_mode(sel_half, sel_quarter);

    generate
        if (DROP > 0) begin : g_decim
            assign mem_addr = (mode == MODE_FULL) ? frame_addr[AW-1:DROP]
                                                  : frame_addr[MAW-1:0];
        end else begin : g_flat
            logic unused_mode;
            assign unused_mode = (mode == MODE_FULL);
            assign mem_addr    = frame_addr[MAW-1:0];
        end
    endgenerate

endmodule

// File: rtl/pixcap_top.sv
module pixcap_top
    import pixcap_pkg::*;
#(
    parameter int DW  = BYTE_W,
    parameter int PW  = PIX_W,
    parameter int AW  = FRAME_AW,
    parameter int MAW = MEM_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           frame_sync,
    input  logic           line_valid,
    input  logic [DW-1:0]  pix_byte,
    input  logic           sel_half,
    input  logic           sel_quarter,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic [PW-1:0]  wr_data,
    output logic [MAW-1:0] mem_addr
);
    logic    pix_stb;
    rgb565_t pix;

    pixcap_pairer #(.DW(DW)) u_pair (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .line_valid (line_valid),
        .pix_byte   (pix_byte),
        .pix_stb    (pix_stb),
        .pix        (pix)
    );

    pixcap_addr_ctr #(.AW(AW)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .pix_stb    (pix_stb),
        .wr_addr    (wr_addr)
    );

    pixcap_addr_map #(.AW(AW), .MAW(MAW)) u_map (
        .frame_addr  (wr_addr),
        .sel_half    (sel_half),
        .sel_quarter (sel_quarter),
        .mem_addr    (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= pix_stb;
            if (pix_stb) wr_data <= PW'(shrink(pix));
        end
    end

    // R3: a pixel needs two bytes, so strobes never touch
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R9: no write follows an edge without line data
    p_idle_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        !line_valid |=> !wr_en);

    // R6: no write follows an edge inside frame sync
    p_sync_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> !wr_en);

    // R5: back-to-back pixels advance the index by one
    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en, 2)) |-> (wr_addr == $past(wr_addr, 2) + 1'b1));

endmodule

// File: tb/pixcap_top_tb_top.sv
module pixcap_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_sync = 1'b0;
    logic        line_valid = 1'b0;
    logic [7:0]  pix_byte = '0;
    logic        sel_half = 1'b0;
    logic        sel_quarter = 1'b0;
    logic        wr_en;
    logic [18:0] wr_addr;
    logic [11:0] wr_data;
    logic [16:0] mem_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pixcap_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .frame_sync  (frame_sync),
        .line_valid  (line_valid),
        .pix_byte    (pix_byte),
        .sel_half    (sel_half),
        .sel_quarter (sel_quarter),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .mem_addr    (mem_addr)
    );

    // {first byte, second byte, expected 4:4:4 word}
    localparam int NVEC = 6;
    localparam logic [27:0] VEC [NVEC] = '{
        {8'hF8, 8'h00, 12'hF00},
        {8'h07, 8'hE0, 12'h0F0},
        {8'h00, 8'h1F, 12'h00F},
        {8'hAE, 8'h6E, 12'hAC7},
        {8'h12, 8'h34, 12'h14A},
        {8'hFF, 8'hFF, 12'hFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic lv, input logic fs);
        @(negedge clk);
        pix_byte   = b;
        line_valid = lv;
        frame_sync = fs;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 wr_en", 32'(wr_en), 0);
        check("R1 wr_addr", 32'(wr_addr), 0);
        check("R1 wr_data", 32'(wr_data), 0);
        @(negedge clk);
        rst = 1'b0;

        send(8'h00, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0);

        // table walk: packing, strobe timing, indexing, full-mode decimation
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][27:20], 1'b1, 1'b0);
            check("R3 low after first byte", 32'(wr_en), 0);
            send(VEC[i][19:12], 1'b1, 1'b0);
            check("R3 high after second byte", 32'(wr_en), 1);
            check("R2 colour word", 32'(wr_data), 32'(VEC[i][11:0]));
            check("R5 pixel index", 32'(wr_addr), i);
            check("R7 decimated address", 32'(mem_addr), i >> 2);
        end

        // R9: idle line holds outputs
        send(8'h5A, 1'b0, 1'b0);
        check("R9 no write", 32'(wr_en), 0);
        check("R9 data held", 32'(wr_data), 32'h0FFF);
        check("R9 index held", 32'(wr_addr), 5);

        // R8: reduced modes map straight through
        @(negedge clk);
        sel_half = 1'b1;
        #1 check("R8 half mode", 32'(mem_addr), 5);
        sel_half = 1'b0; sel_quarter = 1'b1;
        #1 check("R8 quarter mode", 32'(mem_addr), 5);
        sel_half = 1'b1;
        #1 check("R8 both selects", 32'(mem_addr), 5);
        sel_half = 1'b0; sel_quarter = 1'b0;
        #1 check("R7 back to full", 32'(mem_addr), 1);

        // R4: stray byte before line end is dropped
        send(8'hAE, 1'b1, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        check("R4 no write on line end", 32'(wr_en), 0);
        send(8'h12, 1'b1, 1'b0);
        check("R4 new line starts on first byte", 32'(wr_en), 0);
        send(8'h34, 1'b1, 1'b0);
        check("R4 pixel written", 32'(wr_en), 1);
        check("R4 pairing", 32'(wr_data), 32'h014A);
        check("R5 index continues", 32'(wr_addr), 6);

        // R6: bytes under frame sync are ignored, index restarts
        send(8'hF8, 1'b1, 1'b1);
        check("R6 no write in sync", 32'(wr_en), 0);
        send(8'h00, 1'b1, 1'b1);
        check("R6 no write in sync 2", 32'(wr_en), 0);
        check("R6 data unchanged", 32'(wr_data), 32'h014A);
        send(8'h07, 1'b1, 1'b0);
        send(8'hE0, 1'b1, 1'b0);
        check("R6 first pixel write", 32'(wr_en), 1);
        check("R6 index zero", 32'(wr_addr), 0);
        check("R6 data", 32'(wr_data), 32'h00F0);
        send(8'h00, 1'b1, 1'b0);
        send(8'h1F, 1'b1, 1'b0);
        check("R5 second pixel index", 32'(wr_addr), 1);

        // R1: reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 wr_en after reset", 32'(wr_en), 0);
        check("R1 wr_addr after reset", 32'(wr_addr), 0);
        check("R1 wr_data after reset", 32'(wr_data), 0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule